// File: doc/BRIEF.md
# Hierarchical Block-Mismatch Penalty Evaluator

This block scores how far a measured bit string is from a desired bit string. A plain per-bit count treats every wrong bit alike. This block also looks at groups of bits: it compares the two strings in blocks whose size doubles from one level to the next, and any block that holds at least one wrong bit adds its own size to the penalty. The penalties from all selected block sizes are added into one total, so a string that is wrong in scattered places scores worse than one that is wrong in a single cluster.

Two grouping schemes are available. In disjoint mode a size-k block starts at every multiple of k, so the blocks tile the string. In sliding mode a size-k window starts at every bit position, so neighbouring windows overlap. In sliding mode a wrap control decides what happens near the end of the string: the windows there either run on from bit 0 or are not counted. A mask picks the block sizes that count. A start strobe captures all inputs. The block then works through one size per clock cycle, smallest first, and returns the total together with a one-cycle done pulse.

Top module: `fit_hier_eval`

## Requirements
- R1: While reset is held and after it is released, `penalty_o` reads 0 and `done_o` is low until the first evaluation completes.
- R2: The size-1 level (mask bit 0) adds one point for each bit position where `meas_i` and `want_i` differ.
- R3: With `mode_i` = 0 (disjoint), a level with block size k = 2^j adds k for each block of bits [m·k, m·k+k-1], m ≥ 0, that contains a difference.
- R4: With `mode_i` = 1 (sliding) and `wrap_i` = 1, a level of size k tests STR_W windows, one starting at each bit p and covering bits (p+i) mod STR_W for i < k. It adds k for each window that contains a difference.
- R5: With `mode_i` = 1 and `wrap_i` = 0, only the windows with p + k ≤ STR_W are tested (STR_W - k + 1 windows), and each one that contains a difference adds k.
- R6: Mask bit j enables block size 2^j, for j = 0 .. log2(STR_W)-1. The enabled levels are summed, and a zero mask gives a penalty of 0.
- R7: `done_o` is high for exactly one cycle, log2(STR_W) clock cycles after the edge that accepted the start. `penalty_o` takes its new value in that cycle and holds it until the next completion.
- R8: All inputs are sampled at the accepted start. A start, or any input change, during an evaluation has no effect on the result being computed.
- R9: In disjoint mode `wrap_i` has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| start_i | input | 1 | Start strobe; accepted when no evaluation is running |
| mode_i | input | 1 | 0 = disjoint blocks, 1 = sliding windows |
| wrap_i | input | 1 | Sliding mode: 1 = windows wrap past the end to bit 0 |
| size_mask_i | input | log2(STR_W) | Bit j enables block size 2^j |
| meas_i | input | STR_W | Measured bit string |
| want_i | input | STR_W | Desired bit string |
| penalty_o | output | PEN_W | Total penalty of the last evaluation |
| done_o | output | 1 | One-cycle pulse when `penalty_o` is updated |

## Verification
The assertions assume that the environment follows each accepted start to completion before it issues the next one, and that it never pulses start in the reset-synchronisation cycles. They also take the captured mask and difference pattern as the only inputs the result depends on. The stimulus keeps within these assumptions. It raises every start at a falling edge, holds it for one cycle, and waits for done before it issues the next start. The one exception is a deliberate mid-evaluation start, which the checker's own run tracking ignores in the same way the design does. The sweep covers every difference pattern of a small 8-bit configuration in each mode, wrap and mask setting.

// File: rtl/fit_pkg.sv
package fit_pkg;
  typedef enum logic {
    MODE_DISJOINT = 1'b0,
    MODE_SLIDING  = 1'b1
  } fit_mode_e;
endpackage

// File: rtl/fit_rst_sync.sv
module fit_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= 2'b00;
    else        stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_sync_n = stg_q[1];
endmodule

// File: rtl/fit_win_or.sv
// OR of every (circular) window of size 2^lvl, built by doubling.
module fit_win_or #(
  parameter int STR_W = 64,
  parameter int LVL_N = $clog2(STR_W),
  parameter int LVL_W = (LVL_N > 1) ? $clog2(LVL_N) : 1
) (
  input  logic [STR_W-1:0] mis_i,
  input  logic [LVL_W-1:0] lvl_i,
  output logic [STR_W-1:0] hit_o
);
  logic [STR_W-1:0] tab [LVL_N];

  assign tab[0] = mis_i;

  for (genvar j = 1; j < LVL_N; j++) begin : g_lvl
    for (genvar p = 0; p < STR_W; p++) begin : g_pos
      localparam int Q = (p + (1 << (j - 1))) % STR_W;
      assign tab[j][p] = tab[j-1][p] | tab[j-1][Q];
    end
  end

  always_comb begin
    hit_o = tab[0];
    for (int j = 0; j < LVL_N; j++) begin
      if (int'(lvl_i) == j) hit_o = tab[j];
    end
  end
endmodule

// File: rtl/fit_win_valid.sv
// Which window start positions count at the current level.
module fit_win_valid
  import fit_pkg::*;
#(
  parameter int STR_W = 64,
  parameter int LVL_N = $clog2(STR_W),
  parameter int LVL_W = (LVL_N > 1) ? $clog2(LVL_N) : 1
) (
  input  fit_mode_e        mode_i,
  input  logic             wrap_i,
  input  logic [LVL_W-1:0] lvl_i,
  output logic [STR_W-1:0] vld_o
);
  int sz;

  always_comb begin
    sz = 1 << int'(lvl_i);
    for (int p = 0; p < STR_W; p++) begin
      if (mode_i == MODE_DISJOINT) vld_o[p] = ((p & (sz - 1)) == 0);
      else if (wrap_i)             vld_o[p] = 1'b1;
      else                         vld_o[p] = ((p + sz) <= STR_W);
    end
  end
endmodule

// File: rtl/fit_blk_score.sv
// Count of counted mismatching windows, scaled by the block size.
module fit_blk_score #(
  parameter int STR_W = 64,
  parameter int LVL_N = $clog2(STR_W),
  parameter int LVL_W = (LVL_N > 1) ? $clog2(LVL_N) : 1,
  parameter int PEN_W = $clog2(STR_W * STR_W) + 1
) (
  input  logic [STR_W-1:0] hit_i,
  input  logic [STR_W-1:0] vld_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic             en_i,
  output logic [PEN_W-1:0] score_o
);
  localparam int CNT_W = $clog2(STR_W + 1);

  logic [STR_W-1:0] sel;
  logic [CNT_W-1:0] cnt;

  assign sel = hit_i & vld_i;

  always_comb begin
    cnt = '0;
    for (int p = 0; p < STR_W; p++) cnt = cnt + CNT_W'(sel[p]);
  end

  assign score_o = en_i ? (PEN_W'(cnt) << lvl_i) : '0;
endmodule

// File: rtl/fit_hier_eval.sv
module fit_hier_eval
  import fit_pkg::*;
#(
  parameter int STR_W = 64,
  parameter int LVL_N = $clog2(STR_W),
  parameter int LVL_W = (LVL_N > 1) ? $clog2(LVL_N) : 1,
  parameter int PEN_W = $clog2(STR_W * STR_W) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             mode_i,
  input  logic             wrap_i,
  input  logic [LVL_N-1:0] size_mask_i,
  input  logic [STR_W-1:0] meas_i,
  input  logic [STR_W-1:0] want_i,
  output logic [PEN_W-1:0] penalty_o,
  output logic             done_o
);
  localparam logic [LVL_W-1:0] LVL_LAST = LVL_W'(LVL_N - 1);

  logic rst_sync_n;

  fit_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // captured operands
  logic [STR_W-1:0] mis_q, mis_n;
  fit_mode_e        mode_q, mode_n;
  logic             wrap_q, wrap_n;
  logic [LVL_N-1:0] mask_q, mask_n;
  // sequencing
  logic [LVL_W-1:0] lvl_q, lvl_n;
  logic             run_q, run_n;
  logic [PEN_W-1:0] acc_q, acc_n;
  logic [PEN_W-1:0] pen_q, pen_n;
  logic             done_q, done_n;

  logic             ld_en, step_en, fin_en;
  logic [STR_W-1:0] hit, vld;
  logic [PEN_W-1:0] score, acc_sum;

  fit_win_or #(.STR_W(STR_W), .LVL_N(LVL_N), .LVL_W(LVL_W)) u_or (
    .mis_i (mis_q),
    .lvl_i (lvl_q),
    .hit_o (hit)
  );

  fit_win_valid #(.STR_W(STR_W), .LVL_N(LVL_N), .LVL_W(LVL_W)) u_vld (
    .mode_i (mode_q),
    .wrap_i (wrap_q),
    .lvl_i  (lvl_q),
    .vld_o  (vld)
  );

  fit_blk_score #(.STR_W(STR_W), .LVL_N(LVL_N), .LVL_W(LVL_W), .PEN_W(PEN_W)) u_score (
    .hit_i   (hit),
    .vld_i   (vld),
    .lvl_i   (lvl_q),
    .en_i    (mask_q[lvl_q]),
    .score_o (score)
  );

  assign ld_en   = start_i & ~run_q;
  assign step_en = run_q;
  assign fin_en  = run_q & (lvl_q == LVL_LAST);
  assign acc_sum = acc_q + score;

  always_comb begin
    mis_n  = mis_q;
    mode_n = mode_q;
    wrap_n = wrap_q;
    mask_n = mask_q;
    lvl_n  = lvl_q;
    run_n  = run_q;
    acc_n  = acc_q;
    pen_n  = pen_q;
    done_n = 1'b0;
    if (ld_en) begin
      mis_n  = meas_i ^ want_i;
      mode_n = fit_mode_e'(mode_i);
      wrap_n = wrap_i;
      mask_n = size_mask_i;
      lvl_n  = '0;
      acc_n  = '0;
      run_n  = 1'b1;
    end else if (step_en) begin
      acc_n = acc_sum;
      if (fin_en) begin
        run_n  = 1'b0;
        pen_n  = acc_sum;
        done_n = 1'b1;
      end else begin
        lvl_n = lvl_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mis_q  <= '0;
      mode_q <= MODE_DISJOINT;
      wrap_q <= 1'b0;
      mask_q <= '0;
      lvl_q  <= '0;
      run_q  <= 1'b0;
      acc_q  <= '0;
      pen_q  <= '0;
      done_q <= 1'b0;
    end else begin
      mis_q  <= mis_n;
      mode_q <= mode_n;
      wrap_q <= wrap_n;
      mask_q <= mask_n;
      lvl_q  <= lvl_n;
      run_q  <= run_n;
      acc_q  <= acc_n;
      pen_q  <= pen_n;
      done_q <= done_n;
    end
  end

  assign penalty_o = pen_q;
  assign done_o    = done_q;
endmodule

// File: rtl/fit_hier_eval_chk.sv
module fit_hier_eval_chk #(
  parameter int STR_W = 64,
  parameter int LVL_N = $clog2(STR_W),
  parameter int PEN_W = $clog2(STR_W * STR_W) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [LVL_N-1:0] size_mask_i,
  input logic [STR_W-1:0] meas_i,
  input logic [STR_W-1:0] want_i,
  input logic [PEN_W-1:0] penalty_o,
  input logic             done_o
);
  localparam int MAX_PEN = STR_W * (STR_W - 1);

  logic             run_c;
  logic [7:0]       cyc_c;
  logic [STR_W-1:0] mis_c;
  logic [LVL_N-1:0] msk_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_c <= 1'b0;
      cyc_c <= '0;
      mis_c <= '0;
      msk_c <= '0;
    end else if (start_i && (!run_c || done_o)) begin
      run_c <= 1'b1;
      cyc_c <= '0;
      mis_c <= meas_i ^ want_i;
      msk_c <= size_mask_i;
    end else if (run_c) begin
      cyc_c <= cyc_c + 8'd1;
      if (done_o) run_c <= 1'b0;
    end
  end

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(penalty_o));

  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (run_c && (int'(cyc_c) == LVL_N)));

  p_hamming_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && (msk_c == LVL_N'(1))) |-> (int'(penalty_o) == $countones(mis_c)));

  p_zero_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && (msk_c == '0)) |-> (penalty_o == '0));

  p_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(penalty_o) <= MAX_PEN);
endmodule

bind fit_hier_eval fit_hier_eval_chk #(
  .STR_W (STR_W),
  .LVL_N (LVL_N),
  .PEN_W (PEN_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .start_i     (start_i),
  .size_mask_i (size_mask_i),
  .meas_i      (meas_i),
  .want_i      (want_i),
  .penalty_o   (penalty_o),
  .done_o      (done_o)
);

// File: tb/sim_fit_hier_eval.sv
module sim_fit_hier_eval;
  localparam int W   = 8;
  localparam int LVL = $clog2(W);
  localparam int PW  = $clog2(W * W) + 1;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           start_i;
  logic           mode_i;
  logic           wrap_i;
  logic [LVL-1:0] size_mask_i;
  logic [W-1:0]   meas_i;
  logic [W-1:0]   want_i;
  logic [PW-1:0]  penalty_o;
  logic           done_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  fit_hier_eval #(.STR_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .wrap_i(wrap_i), .size_mask_i(size_mask_i), .meas_i(meas_i),
    .want_i(want_i), .penalty_o(penalty_o), .done_o(done_o)
  );

  function automatic int ref_pen(logic [W-1:0] mis, bit mode, bit wrap,
                                 logic [LVL-1:0] mask);
    int total = 0;
    for (int j = 0; j < LVL; j++) begin
      if (mask[j]) begin
        int k = 1 << j;
        for (int p = 0; p < W; p++) begin
          bit use_it = mode ? (wrap || (p + k <= W)) : ((p % k) == 0);
          bit bad = 0;
          for (int i = 0; i < k; i++) bad |= mis[(p + i) % W];
          if (use_it && bad) total += k;
        end
      end
    end
    return total;
  endfunction

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, got, exp);
    end
  endtask

  // Runs one evaluation; returns result and the cycles to done.
  task automatic run_eval(logic [W-1:0] meas, logic [W-1:0] want, bit mode,
                          bit wrap, logic [LVL-1:0] mask, bit disturb,
                          output int pen, output int lat);
    @(negedge clk);
    meas_i = meas; want_i = want; mode_i = mode; wrap_i = wrap;
    size_mask_i = mask; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    lat = 0;
    if (disturb) begin
      meas_i = ~meas; mode_i = ~mode; wrap_i = ~wrap; size_mask_i = ~mask;
    end
    while (!done_o && lat < 50) begin
      @(negedge clk);
      lat++;
      if (disturb && lat == 2) start_i = 1'b1;
      if (disturb && lat == 3) start_i = 1'b0;
    end
    pen = int'(penalty_o);
  endtask

  initial begin
    int pen, lat, exp;
    rst_n = 1'b0; start_i = 1'b0; mode_i = 1'b0; wrap_i = 1'b0;
    size_mask_i = '0; meas_i = '0; want_i = '0;
    repeat (3) @(negedge clk);
    check("R1 penalty in reset", int'(penalty_o), 0);
    check("R1 done in reset", int'(done_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 penalty after reset", int'(penalty_o), 0);
    check("R1 done after reset", int'(done_o), 0);

    // worked disjoint case: sizes 1,2,4 (R3, R6)
    run_eval(8'b1010_0001, 8'b0110_0110, 1'b0, 1'b0, 3'b111, 1'b0, pen, lat);
    check("R3 worked disjoint", pen, 19);
    check("R7 latency", lat, LVL);
    @(negedge clk);
    check("R7 done single pulse", int'(done_o), 0);
    check("R7 penalty held", int'(penalty_o), 19);

    // worked sliding wrap case, size 2 only (R4)
    run_eval(8'b1010_0001, 8'b0110_0110, 1'b1, 1'b1, 3'b010, 1'b0, pen, lat);
    check("R4 worked sliding wrap", pen, 12);

    // start and input changes during evaluation ignored (R8)
    run_eval(8'b1010_0001, 8'b0110_0110, 1'b0, 1'b0, 3'b111, 1'b1, pen, lat);
    check("R8 disturbed evaluation", pen, 19);
    check("R8 latency undisturbed", lat, LVL);
    @(negedge clk);
    check("R8 no second done", int'(done_o), 0);

    // zero mask (R6)
    run_eval(8'hFF, 8'h00, 1'b1, 1'b1, 3'b000, 1'b0, pen, lat);
    check("R6 zero mask", pen, 0);

    // exhaustive sweep of difference patterns
    for (int i = 0; i < 256; i++) begin
      logic [W-1:0] want = W'((i * 37 + 11) & 255);
      logic [W-1:0] mis  = W'(i);
      run_eval(want ^ mis, want, 1'b0, 1'b0, 3'b001, 1'b0, pen, lat);
      check("R2 hamming level", pen, $countones(mis));
      run_eval(want ^ mis, want, 1'b0, 1'b0, 3'b111, 1'b0, pen, lat);
      exp = ref_pen(mis, 1'b0, 1'b0, 3'b111);
      check("R3 disjoint sweep", pen, exp);
      run_eval(want ^ mis, want, 1'b0, 1'b1, 3'b111, 1'b0, pen, lat);
      check("R9 disjoint wrap ignored", pen, exp);
      run_eval(want ^ mis, want, 1'b1, 1'b1, 3'b111, 1'b0, pen, lat);
      check("R4 sliding wrap sweep", pen, ref_pen(mis, 1'b1, 1'b1, 3'b111));
      run_eval(want ^ mis, want, 1'b1, 1'b0, 3'b111, 1'b0, pen, lat);
      check("R5 sliding no-wrap sweep", pen, ref_pen(mis, 1'b1, 1'b0, 3'b111));
      run_eval(want ^ mis, want, i[3], i[4], LVL'(i), 1'b0, pen, lat);
      check("R6 mask sweep", pen, ref_pen(mis, i[3], i[4], LVL'(i)));
      if (lat != LVL) check("R7 sweep latency", lat, LVL);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule